// File: doc/BRIEF.md
# Virtualized TSC Deadline Timer

This block holds the guest-timer state of one virtual CPU for a timer that runs in deadline mode. A guest accesses a single model-specific register address through a simple read/write port. Each write lands in two places. The first is a visible deadline copy, which reads return unchanged. The second is an armed deadline, which the block compares against a free-running timestamp counter. Before it is stored, the armed deadline is converted from guest time to host time using the configured counter offset and an inverse-scale factor.

The armed deadline is nonzero and the counter has reached it. When that holds, the block posts the configured timer vector:

- it sets the vector's bit in a virtual interrupt request vector;
- it raises a requesting-vector byte to the larger of that byte and the vector;
- one cycle later it issues a single-cycle evaluate pulse;
- it clears both deadline registers, so each write produces at most one event.

Top module: `vtsc_deadline_timer`

## Requirements
- R1: The port responds only when `virt_en` is 1 and `msr_addr` equals `MSR_ADDR` (default 0x6E0). Otherwise writes change no state and `msr_rdata` is zero.
- R2: A selected read returns the visible deadline copy on `msr_rdata` in the same cycle. It never returns the armed deadline.
- R3: A selected write stores the whole written value in the visible copy at the next clock edge.
- R4: A selected write of zero clears the armed deadline, and no event occurs whatever the counter does.
- R5: A nonzero write arms the deadline with ((value − `tsc_offset`) mod 2^TW × `inv_scale`) >> FRAC, truncated to TW bits. If that result is zero, the deadline is forced to 1.
- R6: An event occurs at the first clock edge at which the armed deadline is nonzero and `tsc` ≥ deadline, compared as unsigned numbers.
- R7: An event sets bit `timer_vec` of `virr` and leaves the other bits unchanged. No bit of `virr` is ever cleared except by reset.
- R8: An event sets `rvi` to the larger of its present value and `timer_vec`. `rvi` never decreases.
- R9: An event clears both the armed deadline and the visible copy, so later reads return 0 and no second event follows.
- R10: `eval_pulse` is high for exactly one cycle. That cycle starts one clock after the edge that updated `virr` and `rvi`.
- R11: When a selected write and an expiry fall on the same edge, the write is applied and the expiry is dropped.
- R12: Synchronous active-high `rst` clears every register: `virr`, `rvi`, both deadlines and `eval_pulse`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| virt_en | input | 1 | Enables virtualized handling of the deadline register |
| msr_wr | input | 1 | Write strobe |
| msr_rd | input | 1 | Read strobe |
| msr_addr | input | ADDR_W | Register address |
| msr_wdata | input | TW | Write data (guest deadline) |
| msr_rdata | output | TW | Read data: the visible deadline copy, or zero |
| tsc | input | TW | Free-running timestamp counter |
| tsc_offset | input | TW | Offset subtracted from the guest deadline |
| inv_scale | input | TW | Inverse scale factor with FRAC fraction bits |
| timer_vec | input | VEC_W | Vector posted when the timer expires |
| virr | output | 2^VEC_W | Virtual interrupt request bits |
| rvi | output | VEC_W | Highest requesting vector |
| eval_pulse | output | 1 | One-cycle request to evaluate pending virtual interrupts |

## Verification
The bench builds the block with TW=16, FRAC=8 and VEC_W=4. With these values the conversion arithmetic is a 16×16 product that the bench recomputes directly, and the request vector has only 16 bits. A sweep can therefore post every vector once, in a scrambled order, and follow the running maximum of `rvi` across all 16 values. Each posting sets its own offset and scale, including one case where the converted result is zero and one where the subtraction wraps. For each posting the bench holds the counter one below the computed host deadline and then moves it onto that deadline, which checks both the conversion and the exact firing edge.

// File: rtl/vtsc_deadline_timer.sv
module vtsc_deadline_timer #(
  parameter int TW     = 64,
  parameter int FRAC   = 32,
  parameter int VEC_W  = 8,
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] MSR_ADDR = 'h6E0,
  localparam int NVEC  = 1 << VEC_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              virt_en,
  input  logic              msr_wr,
  input  logic              msr_rd,
  input  logic [ADDR_W-1:0] msr_addr,
  input  logic [TW-1:0]     msr_wdata,
  output logic [TW-1:0]     msr_rdata,
  input  logic [TW-1:0]     tsc,
  input  logic [TW-1:0]     tsc_offset,
  input  logic [TW-1:0]     inv_scale,
  input  logic [VEC_W-1:0]  timer_vec,
  output logic [NVEC-1:0]   virr,
  output logic [VEC_W-1:0]  rvi,
  output logic              eval_pulse
);

  logic [TW-1:0]   shadow, deadline, delta, scaled, host_dl;
  logic [2*TW-1:0] product;
  logic            sel, wr_hit, rd_hit, due, fire, posted;

  assign sel    = virt_en && (msr_addr == MSR_ADDR);
  assign wr_hit = sel && msr_wr;
  assign rd_hit = sel && msr_rd;

  assign msr_rdata = rd_hit ? shadow : '0;

  assign delta   = msr_wdata - tsc_offset;
  assign product = {{TW{1'b0}}, delta} * {{TW{1'b0}}, inv_scale};
  assign scaled  = TW'(product >> FRAC);
  assign host_dl = (scaled == '0) ? TW'(1) : scaled;

  assign due  = (deadline != '0) && (tsc >= deadline);
  assign fire = due && !wr_hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      shadow     <= '0;
      deadline   <= '0;
      virr       <= '0;
      rvi        <= '0;
      posted     <= 1'b0;
      eval_pulse <= 1'b0;
    end else begin
      posted     <= fire;
      eval_pulse <= posted;
      if (wr_hit) begin
        shadow   <= msr_wdata;
        deadline <= (msr_wdata == '0) ? '0 : host_dl;
      end else if (fire) begin
        shadow   <= '0;
        deadline <= '0;
        virr     <= virr | ({{(NVEC-1){1'b0}}, 1'b1} << timer_vec);
        if (timer_vec > rvi) rvi <= timer_vec;
      end
    end
  end

endmodule

module vtsc_deadline_timer_chk #(
  parameter int TW    = 64,
  parameter int VEC_W = 8,
  localparam int NVEC = 1 << VEC_W
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_hit,
  input logic             posted,
  input logic             eval_pulse,
  input logic [TW-1:0]    msr_wdata,
  input logic [TW-1:0]    shadow,
  input logic [TW-1:0]    deadline,
  input logic [TW-1:0]    tsc,
  input logic [VEC_W-1:0] timer_vec,
  input logic [NVEC-1:0]  virr,
  input logic [VEC_W-1:0] rvi
);

  assert_shadow_load_R3: assert property (@(posedge clk) disable iff (rst)
    wr_hit |=> (shadow == $past(msr_wdata)));

  assert_expiry_posts_R6: assert property (@(posedge clk) disable iff (rst)
    ((deadline != '0) && (tsc >= deadline) && !wr_hit) |=> virr[$past(timer_vec)]);

  assert_virr_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((virr & $past(virr)) == $past(virr)));

  assert_rvi_monotonic_R8: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (rvi >= $past(rvi)));

  assert_disarm_after_post_R9: assert property (@(posedge clk) disable iff (rst)
    posted |-> ((shadow == '0) && (deadline == '0)));

  assert_eval_single_R10: assert property (@(posedge clk) disable iff (rst)
    eval_pulse |=> !eval_pulse);

  assert_eval_follows_R10: assert property (@(posedge clk) disable iff (rst)
    posted |=> eval_pulse);

  assert_write_wins_R11: assert property (@(posedge clk) disable iff (rst)
    wr_hit |=> !posted);

endmodule

bind vtsc_deadline_timer vtsc_deadline_timer_chk #(.TW(TW), .VEC_W(VEC_W)) u_chk (
  .clk(clk), .rst(rst), .wr_hit(wr_hit), .posted(posted), .eval_pulse(eval_pulse),
  .msr_wdata(msr_wdata), .shadow(shadow), .deadline(deadline), .tsc(tsc),
  .timer_vec(timer_vec), .virr(virr), .rvi(rvi)
);

// File: tb/sim_vtsc_deadline_timer.sv
module sim_vtsc_deadline_timer;
  localparam int TW = 16, FRAC = 8, VEC_W = 4, NV = 16;

  logic clk = 0, rst = 1, virt_en = 0, msr_wr = 0, msr_rd = 0;
  logic [11:0] msr_addr = 12'h6E0;
  logic [TW-1:0] msr_wdata = 0, tsc = 0, tsc_offset = 0, inv_scale = 16'h0100;
  logic [VEC_W-1:0] timer_vec = 0;
  wire  [TW-1:0] msr_rdata;
  wire  [NV-1:0] virr;
  wire  [VEC_W-1:0] rvi;
  wire  eval_pulse;

  int total = 0, fails = 0;

  vtsc_deadline_timer #(.TW(TW), .FRAC(FRAC), .VEC_W(VEC_W)) u0 (
    .clk(clk), .rst(rst), .virt_en(virt_en), .msr_wr(msr_wr), .msr_rd(msr_rd),
    .msr_addr(msr_addr), .msr_wdata(msr_wdata), .msr_rdata(msr_rdata), .tsc(tsc),
    .tsc_offset(tsc_offset), .inv_scale(inv_scale), .timer_vec(timer_vec),
    .virr(virr), .rvi(rvi), .eval_pulse(eval_pulse));

  always #4 clk = ~clk;

  task automatic chk(string tag, longint act, longint exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick(int n = 1);
    for (int k = 0; k < n; k++) begin @(posedge clk); #1; end
  endtask

  task automatic mwrite(logic [11:0] a, logic [TW-1:0] d);
    msr_addr = a; msr_wdata = d; msr_wr = 1; tick(); msr_wr = 0; msr_addr = 12'h6E0;
  endtask

  task automatic mread(output logic [TW-1:0] d);
    msr_rd = 1; #1; d = msr_rdata; msr_rd = 0;
  endtask

  initial begin
    #1600000;
    fails++; total++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    logic [TW-1:0] rd;
    logic [NV-1:0] exp_virr;
    logic [VEC_W-1:0] exp_rvi;
    tick(3); rst = 0; virt_en = 1;
    chk("R12 virr reset", virr, 0);
    chk("R12 rvi reset", rvi, 0);
    chk("R12 eval reset", eval_pulse, 0);
    mread(rd); chk("R12 shadow reset", rd, 0);

    virt_en = 0; mwrite(12'h6E0, 16'h1234); virt_en = 1;
    mread(rd); chk("R1 write ignored when disabled", rd, 0);
    mwrite(12'h6E1, 16'h4321);
    mread(rd); chk("R1 write ignored at other address", rd, 0);
    tsc = 16'hFFFF; tick(3);
    chk("R1 ignored writes arm nothing", virr, 0);
    tsc = 0;

    mwrite(12'h6E0, 16'h0050);
    mread(rd); chk("R2 R3 read shadow", rd, 16'h0050);
    virt_en = 0; mread(rd); virt_en = 1; chk("R1 read zero when disabled", rd, 0);
    msr_addr = 12'h6E2; mread(rd); msr_addr = 12'h6E0; chk("R1 read zero at other address", rd, 0);

    mwrite(12'h6E0, 16'h0000);
    mread(rd); chk("R4 zero write clears shadow", rd, 0);
    tsc = 16'hFFFF; tick(4);
    chk("R4 zero write disarms", virr, 0);
    chk("R4 no eval", eval_pulse, 0);
    tsc = 0;

    mwrite(12'h6E0, 16'h0040);
    tsc = 16'h0100;
    mwrite(12'h6E0, 16'h9000);
    tick(3);
    chk("R11 expiry dropped on write", virr, 0);
    chk("R11 rvi untouched", rvi, 0);
    mread(rd); chk("R11 write applied", rd, 16'h9000);
    tsc = 0; mwrite(12'h6E0, 0);

    exp_virr = 0; exp_rvi = 0;
    for (int i = 0; i < NV; i++) begin
      logic [VEC_W-1:0] v;
      logic [TW-1:0] val, off, sc, host;
      longint d, p;
      v   = VEC_W'((i * 5 + 3) % NV);
      val = TW'(16'h1000 + i * 16'h0731);
      off = TW'(i * 16'h0123);
      sc  = TW'(16'h0080 + i * 16'h0011);
      if (i == 4) off = val;
      if (i == 9) off = val + 5;
      d = longint'(TW'(val - off));
      p = d * longint'(sc);
      host = TW'(p >> FRAC);
      if (host == 0) host = 1;
      tsc = 0; tsc_offset = off; inv_scale = sc; timer_vec = v;
      mwrite(12'h6E0, val);
      mread(rd); chk("R3 shadow holds written value", rd, val);
      tsc = host - 1; tick(2);
      chk("R5 R6 no event below deadline", virr, exp_virr);
      chk("R10 no eval before event", eval_pulse, 0);
      tsc = host; tick();
      exp_virr[v] = 1'b1;
      if (v > exp_rvi) exp_rvi = v;
      chk("R5 R6 R7 event at converted deadline", virr, exp_virr);
      chk("R8 rvi max", rvi, exp_rvi);
      chk("R10 eval not yet", eval_pulse, 0);
      mread(rd); chk("R9 shadow cleared", rd, 0);
      tick(); chk("R10 eval high", eval_pulse, 1);
      tick(); chk("R10 eval one cycle", eval_pulse, 0);
      timer_vec = ~v; tsc = 16'hFFFF; tick(3);
      chk("R9 no second event", virr, exp_virr);
      chk("R9 rvi stable", rvi, exp_rvi);
    end

    rst = 1; tick(); rst = 0;
    chk("R12 virr cleared by reset", virr, 0);
    chk("R12 rvi cleared by reset", rvi, 0);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule